// File: doc/BRIEF.md
# Per-Channel Duty-Cycle Safety Limiter

This block watches a group of serial data lanes and shuts off any lane whose long-run share of high bits stays above 57%. Each lane has its own monitor. A monitor takes one sample of its line per bit period and turns the sample into a signed step: a high bit adds 43 and a low bit subtracts 57. The monitor sums these steps in a leaky accumulator that cannot fall below zero. A lane that runs at exactly 57% high therefore drifts nowhere. A lane that runs above 57% climbs steadily.

When a lane's level reaches the trip threshold, its enable bit drops and its alert bit rises. The trip threshold is 43 times the response window, counted in bit periods. The lane opens again by itself once its level decays below a lower release threshold, and no reset is needed. The gap between the two thresholds keeps the gate from chattering. The level is clamped at the trip threshold, so the time to recover does not grow with the length of a violation. The output gate and the laser or driver hardware sit outside this block. They simply use the enable vector.

Top module: `duty_guard`

## Requirements
- R1: Synchronous reset (rst high) clears every accumulator and drives lane_en to all ones and lane_alert to all zeros. After reset, a lane takes the full window of high samples to trip, whatever was sampled during reset.
- R2: With the defaults (window 64 bits), a lane fed only high samples from a clear state is still enabled after 63 samples. It is disabled (lane_en bit 0, lane_alert bit 1) on the edge that registers the 64th sample. Bit i of each vector belongs to bit i of bit_smp.
- R3: A lane whose duty cycle is 57% or less never trips. This holds at 50% and at 57%, whether the high bits come in one burst of up to 57 per 100 or are spread evenly.
- R4: A lane above 57% trips. A repeating pattern of three high then two low samples (60%) leaves a lane enabled after sample 877 and disabled at sample 878.
- R5: A tripped lane re-enables by itself with no reset. From the clamped level (2752), 24 low samples leave it off and the 25th turns it back on.
- R6: Hysteresis. A low sample never disables an enabled lane. A high sample never re-enables a disabled lane. A tripped lane that has decayed only partway stays off. After a trip, 20 low samples, one high sample and then 4 low samples leave the lane off. One more low sample turns it on.
- R7: Lanes are independent. A trip or a recovery on one lane leaves every other lane's bits unchanged.
- R8: The accumulator floors at zero. After a short high burst and a long run of low samples, a lane again needs exactly 64 high samples to trip.
- R9: The accumulator clamps at the trip level. After 1000 high samples, recovery takes the same 25 low samples as after a 64-sample violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_smp | input | NUM_CH (12) | One sample per lane, taken once per bit period |
| lane_en | output | NUM_CH (12) | High: lane gate open |
| lane_alert | output | NUM_CH (12) | High: lane shut off for excess duty |

## Verification
A wrong accumulator value shows up only as a wrong trip or release time. A step-size or clamp error therefore appears as a lane that changes state one or more samples early or late. The tests pin the exact edge: sample 64 for a constant high, sample 878 for the 60% pattern, and the 25th low sample for recovery. A missing floor or ceiling shows up the next time the lane trips or recovers. Cross-lane leakage shows up on the very edge where the other lane changes state.

// File: rtl/duty_guard_pkg.sv
package duty_guard_pkg;

   // Width needed to hold values 0..v
   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

   typedef enum logic {
      LANE_OPEN = 1'b0,
      LANE_SHUT = 1'b1
   } lane_state_e;

endpackage

// File: rtl/duty_guard_acc.sv
module duty_guard_acc #(
   parameter int unsigned UP   = 43,
   parameter int unsigned DN   = 57,
   parameter int unsigned CEIL = 2752,
   parameter int unsigned W    = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bit_in,
   output logic [W-1:0] lvl_nxt
);
   localparam int unsigned WS = W + 1;

   logic [W-1:0]  lvl_q;
   logic [WS-1:0] raised;

   always_comb begin
      raised = {1'b0, lvl_q} + WS'(UP);
      if (bit_in) begin
         lvl_nxt = (raised >= WS'(CEIL)) ? W'(CEIL) : raised[W-1:0];
      end else begin
         lvl_nxt = (lvl_q >= W'(DN)) ? (lvl_q - W'(DN)) : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl_nxt;
   end
endmodule

// File: rtl/duty_guard_hyst.sv
module duty_guard_hyst
   import duty_guard_pkg::*;
#(
   parameter int unsigned TRIP = 2752,
   parameter int unsigned REL  = 1376,
   parameter int unsigned W    = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   output logic         shut
);
   lane_state_e st_q;

   always_ff @(posedge clk) begin
      if (rst)                  st_q <= LANE_OPEN;
      else if (lvl >= W'(TRIP)) st_q <= LANE_SHUT;
      else if (lvl <  W'(REL))  st_q <= LANE_OPEN;
   end

   assign shut = (st_q == LANE_SHUT);
endmodule

// File: rtl/duty_guard_lane.sv
module duty_guard_lane #(
   parameter int unsigned UP   = 43,
   parameter int unsigned DN   = 57,
   parameter int unsigned TRIP = 2752,
   parameter int unsigned REL  = 1376,
   parameter int unsigned CEIL = 2752,
   parameter int unsigned W    = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic en,
   output logic alert
);
   logic [W-1:0] lvl;
   logic         shut;

   duty_guard_acc #(.UP(UP), .DN(DN), .CEIL(CEIL), .W(W)) acc_i (
      .clk(clk), .rst(rst), .bit_in(bit_in), .lvl_nxt(lvl)
   );

   duty_guard_hyst #(.TRIP(TRIP), .REL(REL), .W(W)) hyst_i (
      .clk(clk), .rst(rst), .lvl(lvl), .shut(shut)
   );

   assign en    = ~shut;
   assign alert = shut;
endmodule

// File: rtl/duty_guard.sv
module duty_guard
   import duty_guard_pkg::*;
#(
   parameter int unsigned NUM_CH        = 12,
   parameter int unsigned UP_STEP       = 43,
   parameter int unsigned DN_STEP       = 57,
   parameter int unsigned WINDOW_BITS   = 64,
   parameter int unsigned RELEASE_LEVEL = (UP_STEP * WINDOW_BITS) / 2,
   parameter bit          SAT_AT_TRIP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] bit_smp,
   output logic [NUM_CH-1:0] lane_en,
   output logic [NUM_CH-1:0] lane_alert
);
   localparam int unsigned TRIP_LEVEL = UP_STEP * WINDOW_BITS;
   localparam int unsigned ACC_W      = SAT_AT_TRIP ? bits_for(TRIP_LEVEL)
                                                    : bits_for(TRIP_LEVEL) + 1;
   localparam int unsigned CEIL_LVL   = SAT_AT_TRIP ? TRIP_LEVEL
                                                    : (1 << ACC_W) - 1;

   if (NUM_CH == 0) begin : g_bad_nch
      $error("duty_guard: NUM_CH must be at least 1");
   end
   if (UP_STEP == 0 || DN_STEP == 0) begin : g_bad_step
      $error("duty_guard: step sizes must be nonzero");
   end
   if (RELEASE_LEVEL == 0 || RELEASE_LEVEL >= TRIP_LEVEL) begin : g_bad_rel
      $error("duty_guard: release level must lie in 1..TRIP_LEVEL-1");
   end
   if (DN_STEP >= TRIP_LEVEL) begin : g_bad_dn
      $error("duty_guard: down step must be below the trip level");
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
      duty_guard_lane #(
         .UP(UP_STEP), .DN(DN_STEP), .TRIP(TRIP_LEVEL),
         .REL(RELEASE_LEVEL), .CEIL(CEIL_LVL), .W(ACC_W)
      ) lane_i (
         .clk   (clk),
         .rst   (rst),
         .bit_in(bit_smp[i]),
         .en    (lane_en[i]),
         .alert (lane_alert[i])
      );
   end
endmodule

// File: rtl/duty_guard_chk.sv
module duty_guard_chk
   import duty_guard_pkg::*;
#(
   parameter int unsigned NUM_CH        = 12,
   parameter int unsigned DN_STEP       = 57,
   parameter int unsigned WINDOW_BITS   = 64,
   parameter int unsigned RELEASE_LEVEL = 1376,
   parameter int unsigned CEIL_LVL      = 2752
) (
   input logic              clk,
   input logic              rst,
   input logic [NUM_CH-1:0] bit_smp,
   input logic [NUM_CH-1:0] lane_en,
   input logic [NUM_CH-1:0] lane_alert
);
   localparam int unsigned REL_ZEROS = (CEIL_LVL - RELEASE_LEVEL) / DN_STEP + 1;
   localparam int unsigned OW = bits_for(WINDOW_BITS);
   localparam int unsigned ZW = bits_for(REL_ZEROS);

   AST_ZERO_KEEPS_OPEN: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((($past(lane_en) & ~$past(bit_smp)) & ~lane_en) == '0)); // R6
   AST_ONE_KEEPS_SHUT: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((($past(lane_alert) & $past(bit_smp)) & ~lane_alert) == '0)); // R6

   for (genvar i = 0; i < NUM_CH; i++) begin : g_win
      logic [OW-1:0] ones_run;
      logic [ZW-1:0] zero_run;

      always_ff @(posedge clk) begin
         if (rst) begin
            ones_run <= '0;
            zero_run <= '0;
         end else if (bit_smp[i]) begin
            zero_run <= '0;
            if (ones_run != OW'(WINDOW_BITS)) ones_run <= ones_run + 1'b1;
         end else begin
            ones_run <= '0;
            if (zero_run != ZW'(REL_ZEROS)) zero_run <= zero_run + 1'b1;
         end
      end

      AST_FULL_WINDOW_TRIPS: assert property (@(posedge clk) disable iff (rst)
         (ones_run == OW'(WINDOW_BITS)) |-> lane_alert[i]); // R2
      AST_LOW_RUN_RELEASES: assert property (@(posedge clk) disable iff (rst)
         (zero_run == ZW'(REL_ZEROS)) |-> lane_en[i]); // R5
   end
endmodule

bind duty_guard duty_guard_chk #(
   .NUM_CH(NUM_CH), .DN_STEP(DN_STEP), .WINDOW_BITS(WINDOW_BITS),
   .RELEASE_LEVEL(RELEASE_LEVEL), .CEIL_LVL(CEIL_LVL)
) chk_i (
   .clk(clk), .rst(rst), .bit_smp(bit_smp),
   .lane_en(lane_en), .lane_alert(lane_alert)
);

// File: tb/duty_guard_tb_top.sv
`timescale 1ns/1ps
module duty_guard_tb_top;
   localparam int NCH = 12;
   localparam logic [NCH-1:0] ALL = '1;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NCH-1:0] smp = '0;
   logic [NCH-1:0] en, al;
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   duty_guard dut_i (
      .clk(clk), .rst(rst), .bit_smp(smp), .lane_en(en), .lane_alert(al)
   );

   task automatic chk(input string req, input string what,
                      input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic push(input logic [NCH-1:0] v);
      smp = v;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic [NCH-1:0] v);
      rst = 1'b1;
      smp = v;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      smp = '0;
   endtask

   task automatic t_reset();
      do_reset(ALL);
      chk("R1", "enable after reset", en, ALL);
      chk("R1", "alert after reset", al, '0);
      repeat (63) push(ALL);
      chk("R1", "accumulators clear, 63 ones", al, '0);
   endtask

   task automatic t_all_ones();
      logic [NCH-1:0] m = 12'h001;
      do_reset('0);
      repeat (63) push(m);
      chk("R2", "after 63 ones", en, ALL);
      push(m);
      chk("R2", "enable after 64 ones", en, ~m);
      chk("R2", "alert after 64 ones", al, m);
      repeat (24) push('0);
      chk("R5", "after 24 zeros still shut", al, m);
      push('0);
      chk("R5", "after 25 zeros reopened", al, '0);
      chk("R5", "enable reopened", en, ALL);
   endtask

   task automatic t_hyst();
      logic [NCH-1:0] m = 12'h002;
      do_reset('0);
      repeat (64) push(m);
      chk("R6", "tripped", al, m);
      repeat (20) push('0);
      chk("R6", "partial decay stays shut", al, m);
      push(m);
      chk("R6", "one does not reopen", al, m);
      repeat (4) push('0);
      chk("R6", "four more zeros still shut", al, m);
      push('0);
      chk("R6", "below release reopens", al, '0);
   endtask

   task automatic t_low_duty();
      logic [NCH-1:0] seen = '0;
      do_reset('0);
      for (int k = 0; k < 1000; k++) begin
         logic [NCH-1:0] v;
         for (int c = 0; c < NCH; c++) begin
            if (c % 2 == 0)  v[c] = ((k % 100) < 50);
            else if (c < 6)  v[c] = ((k % 100) < 57);
            else             v[c] = (((k * 57) % 100) < 57);
         end
         push(v);
         seen |= al;
      end
      chk("R3", "no trip at 50%/57% over 1000 bits", seen, '0);
      chk("R3", "all enabled at end", en, ALL);
   endtask

   task automatic t_high_duty();
      logic [NCH-1:0] m = 12'h0F0;
      do_reset('0);
      for (int k = 0; k < 877; k++) push(((k % 5) < 3) ? m : '0);
      chk("R4", "60% after 877 samples", al, '0);
      push(m);
      chk("R4", "60% trips at sample 878", al, m);
      chk("R7", "other lanes open", en, ~m);
   endtask

   task automatic t_isolation();
      logic [NCH-1:0] m = 12'h020;
      logic [NCH-1:0] alt;
      do_reset('0);
      for (int k = 0; k < 64; k++) begin
         alt = (k % 2 == 0) ? ~m : '0;
         push(alt | m);
         if (k == 62) chk("R7", "no alert before trip", al, '0);
      end
      chk("R7", "only lane 5 shut", al, m);
      for (int k = 0; k < 25; k++) begin
         alt = (k % 2 == 0) ? ~m : '0;
         push(alt);
         if (k == 23) chk("R7", "lane 5 still shut, others open", en, ~m);
      end
      chk("R7", "lane 5 reopened alone", en, ALL);
   endtask

   task automatic t_floor();
      logic [NCH-1:0] m = 12'h004;
      do_reset('0);
      repeat (10) push(m);
      repeat (300) push('0);
      repeat (63) push(m);
      chk("R8", "floor: 63 ones after long low", al, '0);
      push(m);
      chk("R8", "floor: 64th one trips", al, m);
   endtask

   task automatic t_ceiling();
      logic [NCH-1:0] m = 12'h200;
      do_reset('0);
      repeat (1000) push(m);
      chk("R9", "long violation shut", al, m);
      repeat (24) push('0);
      chk("R9", "24 zeros still shut", al, m);
      push('0);
      chk("R9", "25th zero reopens", al, '0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      t_reset();
      t_all_ones();
      t_hyst();
      t_low_duty();
      t_high_duty();
      t_isolation();
      t_floor();
      t_ceiling();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
   end
endmodule